// File: doc/BRIEF.md
# Dual-Buffer HDLC Frame Transmitter

This block sends HDLC frames one bit at a time on a path maintenance data link. A microprocessor loads the message into two 64-byte buffers through a plain byte write port. It then marks which buffer holds the last message byte and gives that byte's position inside the buffer. While the link is enabled and no frame is due, the line carries back-to-back flag bytes. On a rising edge of the send request, the block waits for the current flag to finish. It then sends an opening flag, the selected buffer bytes, an optional 16-bit frame check sequence and a closing flag. After that it raises a done indication and returns to idle flags.

The transmitter only reads the buffers and the control inputs and never changes them. Toggling the send request therefore sends the same frame again. With the check sequence switched off, the last two buffer bytes go out exactly as written. Software can use this to put a deliberately corrupted check value on the line. Each pulse of a transmit clock-enable strobe moves one line bit.

Top module: `hdlc_dbuf_tx`

## Requirements
- R1: With link_en high and no pending request, tx_bit carries an unbroken series of flag bytes 0x7E, with nothing between them.
- R2: While link_en is low, every tx_ce strobe drives tx_bit to 1. After reset, tx_bit is 1 and done is 0.
- R3: Frame payload is read in address order: buffer 0 at wr_addr 0..63, then buffer 1 at wr_addr 64..127 (the address MSB selects the buffer). The payload ends at index last_idx of buffer 0 when buf0_last is 1. Otherwise it ends at index last_idx of buffer 1 when buf1_last is 1. Otherwise it ends after all 128 bytes. buf0_last takes precedence over buf1_last.
- R4: Inside the payload and check fields, a 0 is inserted after every five consecutive 1s, including at the end of a field just before the closing flag. The line never carries more than six 1s in a row while enabled.
- R5: With fcs_en high, the payload is followed by the ones complement of a CRC-16. The CRC uses polynomial x^16+x^12+x^5+1, is preset to 0xFFFF, and is computed over the payload bits least significant bit first. The low check byte is sent first, and every byte is sent least significant bit first.
- R6: With fcs_en low, the closing flag directly follows the last payload byte. No check bytes are added, so buffer bytes written with a wrong check value appear unchanged.
- R7: done rises only on a tx_ce strobe, after the last bit of the closing flag. It falls when the opening flag of the next frame begins.
- R8: Only a 0-to-1 transition of send_req starts a frame, and the request takes effect at a flag boundary. Holding send_req high sends nothing more. Toggling it low and high again resends an identical frame.
- R9: tx_bit changes only on cycles where tx_ce is high. Frames are correct for any tx_ce density.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Enables flag and frame output |
| send_req | input | 1 | Send request, acted on at its rising edge |
| fcs_en | input | 1 | Appends the CRC-16 check bytes |
| buf0_last | input | 1 | Buffer 0 holds the last payload byte |
| buf1_last | input | 1 | Buffer 1 holds the last payload byte |
| last_idx | input | 6 | Index of the last payload byte within its buffer |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 7 | Buffer write address, MSB selects the buffer |
| wr_data | input | 8 | Buffer write byte |
| tx_ce | input | 1 | Transmit bit strobe |
| tx_bit | output | 1 | Serial line bit |
| done | output | 1 | Frame complete indication |

## Verification
The bench decodes the line with its own flag-detecting, bit-destuffing receiver and compares every frame with one built from its mirror of the buffers and an independent CRC. Random payloads under the published 79-byte layout check the normal byte order and check sequence. All-ones payloads, payloads full of flag patterns and 0x1F/0xF8 pairs force stuffing at byte borders and at the field end, which separates correct and missing zero insertion. End-selection patterns (both end flags set, neither set, end in buffer 0) separate the priority of the end flags. Sparse strobes and a held versus a toggled request separate strobe handling and edge detection from level behaviour.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS_LO, ST_FCS_HI, ST_CLOSE
  } tx_state_e;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [2:0]  STUFF_RUN    = 3'd5;

  // one step of the bit-reflected CRC-16 register
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_REV : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_msg_ram.sv
module hdlc_msg_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hdlc_req_edge.sv
module hdlc_req_edge (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req_in,
  input  logic take,
  output logic pending
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_q <= req_in;
      if (!enable || take) pending <= 1'b0;
      else if (req_in && !req_q) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_tx_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic              tx_ce,
  input  logic              fcs_en,
  input  logic              buf0_last,
  input  logic              buf1_last,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              pending,
  output logic              take,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              tx_bit,
  output logic              done
);
  tx_state_e         st, nst;
  logic [7:0]        sh, nbyte, fcs_hi;
  logic [2:0]        rem, ones;
  logic [15:0]       crc;
  logic [ADDR_W-1:0] pos;
  logic              last_r, pos_last, cur_stuffable, nst_stuffable;
  logic              stuff_now, need_load;

  assign rd_addr       = pos;
  assign cur_stuffable = (st == ST_DATA) || (st == ST_FCS_LO) || (st == ST_FCS_HI);
  assign nst_stuffable = (nst == ST_DATA) || (nst == ST_FCS_LO) || (nst == ST_FCS_HI);
  assign stuff_now     = cur_stuffable && (ones == STUFF_RUN);
  assign need_load     = !stuff_now && (rem == 3'd0);
  assign take          = tx_ce && link_en && need_load && (st == ST_IDLE) && pending;

  // end-of-payload decision; buffer 0 end flag wins
  always_comb begin
    pos_last = &pos;
    if (pos[IDX_W-1:0] == last_idx) begin
      if (!pos[ADDR_W-1] && buf0_last) pos_last = 1'b1;
      if (pos[ADDR_W-1] && buf1_last && !buf0_last) pos_last = 1'b1;
    end
  end

  always_comb begin
    nst   = ST_IDLE;
    nbyte = FLAG_BYTE;
    case (st)
      ST_IDLE:   if (pending) nst = ST_OPEN;
      ST_OPEN:   begin nst = ST_DATA; nbyte = rd_data; end
      ST_DATA: begin
        if (!last_r) begin
          nst = ST_DATA; nbyte = rd_data;
        end else if (fcs_en) begin
          nst = ST_FCS_LO; nbyte = ~crc[7:0];
        end else begin
          nst = ST_CLOSE;
        end
      end
      ST_FCS_LO: begin nst = ST_FCS_HI; nbyte = fcs_hi; end
      ST_FCS_HI: nst = ST_CLOSE;
      default:   nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      sh     <= '0;
      rem    <= '0;
      ones   <= '0;
      crc    <= CRC_PRESET;
      pos    <= '0;
      last_r <= 1'b0;
      fcs_hi <= '0;
      tx_bit <= 1'b1;
      done   <= 1'b0;
    end else if (tx_ce) begin
      if (!link_en) begin
        tx_bit <= 1'b1;
        st     <= ST_IDLE;
        rem    <= '0;
        ones   <= '0;
        pos    <= '0;
      end else if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else if (rem != 3'd0) begin
        tx_bit <= sh[0];
        sh     <= {1'b0, sh[7:1]};
        rem    <= rem - 3'd1;
        if (cur_stuffable) ones <= sh[0] ? ones + 3'd1 : 3'd0;
        if (st == ST_DATA) crc <= crc_step(crc, sh[0]);
      end else begin
        tx_bit <= nbyte[0];
        sh     <= {1'b0, nbyte[7:1]};
        rem    <= 3'd7;
        st     <= nst;
        ones   <= (nst_stuffable && nbyte[0]) ? ones + 3'd1 : 3'd0;
        if (st == ST_CLOSE) done <= 1'b1;
        case (nst)
          ST_OPEN: begin
            crc  <= CRC_PRESET;
            done <= 1'b0;
            pos  <= '0;
          end
          ST_DATA: begin
            crc    <= crc_step(crc, nbyte[0]);
            last_r <= pos_last;
            pos    <= pos + {{(ADDR_W-1){1'b0}}, 1'b1};
          end
          ST_FCS_LO: fcs_hi <= ~crc[15:8];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_dbuf_tx.sv
module hdlc_dbuf_tx #(
  parameter int BUF_BYTES = 64,
  localparam int IDX_W  = $clog2(BUF_BYTES),
  localparam int ADDR_W = IDX_W + 1,
  localparam int DEPTH  = 2 * BUF_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic              send_req,
  input  logic              fcs_en,
  input  logic              buf0_last,
  input  logic              buf1_last,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tx_ce,
  output logic              tx_bit,
  output logic              done
);
  logic              pending, take;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  hdlc_msg_ram #(.DATA_W(8), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  hdlc_req_edge u_req (
    .clk(clk), .rst(rst), .enable(link_en), .req_in(send_req),
    .take(take), .pending(pending)
  );

  hdlc_tx_engine #(.IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .link_en(link_en), .tx_ce(tx_ce),
    .fcs_en(fcs_en), .buf0_last(buf0_last), .buf1_last(buf1_last),
    .last_idx(last_idx), .pending(pending), .take(take),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_bit(tx_bit), .done(done)
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
  input logic clk,
  input logic rst,
  input logic link_en,
  input logic tx_ce,
  input logic tx_bit,
  input logic done
);
  logic       ce_q, en_q;
  logic [2:0] run;

  // length of the current run of 1s on the enabled line
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b0;
      en_q <= 1'b0;
      run  <= '0;
    end else begin
      ce_q <= tx_ce;
      en_q <= link_en;
      if (ce_q) begin
        if (!en_q || !tx_bit) run <= '0;
        else if (run != 3'd7) run <= run + 3'd1;
      end
    end
  end

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !tx_ce |=> $stable(tx_bit)); // R9
  AST_DISABLED_MARK: assert property (@(posedge clk) disable iff (rst)
    (tx_ce && !link_en) |=> tx_bit); // R2
  AST_ONES_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    run <= 3'd6); // R4
  AST_DONE_RISE_ON_CE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(tx_ce) && $past(link_en))); // R7
  AST_DONE_FALL_ON_CE: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(tx_ce)); // R7
endmodule

bind hdlc_dbuf_tx hdlc_tx_chk u_chk (
  .clk(clk), .rst(rst), .link_en(link_en), .tx_ce(tx_ce),
  .tx_bit(tx_bit), .done(done)
);

// File: tb/sim_hdlc_dbuf_tx.sv
module sim_hdlc_dbuf_tx;
  logic       clk = 1'b0, rst = 1'b1;
  logic       link_en = 1'b0, send_req = 1'b0, fcs_en = 1'b0;
  logic       buf0_last = 1'b0, buf1_last = 1'b0;
  logic [5:0] last_idx = '0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx_ce = 1'b0;
  logic       tx_bit, done;

  int checks = 0, fails = 0;
  int ce_pct = 100;

  hdlc_dbuf_tx u0 (.*);

  always #2 clk = ~clk;

  // strobe generation
  always @(negedge clk) tx_ce <= (($urandom % 100) < ce_pct);

  // ---------------- line receiver model ----------------
  logic       ce_q = 1'b0;
  logic [7:0] raw = 8'h00;
  int         nb = 0, r_ones = 0;
  logic       bits [1200];
  bit         armed = 1'b0;
  int         idle_flags = 0, frames = 0, misaligned = 0, last_len = 0;
  logic [7:0] last_frame [140];

  always @(posedge clk) ce_q <= tx_ce;

  always @(negedge clk) begin
    if (ce_q) begin
      raw = {tx_bit, raw[7:1]};
      if (raw == 8'h7E) begin
        if (armed) begin
          if (nb == 7) idle_flags++;
          else if (nb >= 15 && ((nb - 7) % 8) == 0 && (nb - 7) / 8 <= 140) begin
            frames++;
            last_len = (nb - 7) / 8;
            for (int k = 0; k < last_len; k++)
              for (int j = 0; j < 8; j++) last_frame[k][j] = bits[k*8+j];
          end else misaligned++;
        end
        nb = 0;
        r_ones = 0;
      end else if (r_ones == 5 && !tx_bit) begin
        r_ones = 0;
      end else begin
        if (nb < 1200) bits[nb] = tx_bit;
        nb++;
        r_ones = tx_bit ? r_ones + 1 : 0;
      end
    end
  end

  // ---------------- reference model ----------------
  logic [7:0] mirror [128];
  logic [7:0] expf [140];
  int         exp_len;

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ expf[i][j]) c = (c >> 1) ^ 16'h8408;
        else c = c >> 1;
      end
    return c;
  endfunction

  task automatic build_exp(input bit b0, input bit b1, input int idx, input bit fcs);
    logic [15:0] c;
    exp_len = 0;
    for (int p = 0; p < 128; p++) begin
      expf[exp_len] = mirror[p];
      exp_len++;
      if (p < 64 && b0 && p == idx) break;
      if (p >= 64 && b1 && !b0 && (p - 64) == idx) break;
    end
    if (fcs) begin
      c = ref_crc(exp_len);
      expf[exp_len] = ~c[7:0];
      expf[exp_len+1] = ~c[15:8];
      exp_len += 2;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
    mirror[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input bit lvl, output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 60000; t++) begin
      @(negedge clk);
      if (done == lvl) begin ok = 1'b1; break; end
    end
  endtask

  task automatic send_frame(input bit b0, input bit b1, input int idx,
                            input bit fcs, input string req);
    bit ok;
    int f0, mism, fa, fe;
    f0 = frames;
    @(negedge clk);
    buf0_last = b0; buf1_last = b1; last_idx = 6'(idx); fcs_en = fcs;
    send_req = 1'b0;
    repeat (3) @(negedge clk);
    send_req = 1'b1;
    wait_level(1'b0, ok);
    chk(ok, "R7", "done falls at frame start", int'(done), 0);
    wait_level(1'b1, ok);
    chk(ok, "R7", "done rises after closing flag", int'(done), 1);
    build_exp(b0, b1, idx, fcs);
    chk(frames == f0 + 1, req, "frame count", frames, f0 + 1);
    chk(last_len == exp_len, req, "frame length", last_len, exp_len);
    mism = 0; fa = 0; fe = 0;
    for (int k = 0; k < exp_len && k < last_len; k++)
      if (last_frame[k] !== expf[k]) begin
        if (mism == 0) begin fa = int'(last_frame[k]); fe = int'(expf[k]); end
        mism++;
      end
    chk(mism == 0, req, "frame bytes (first mismatch shown)", fa, fe);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ones_seen, f0, fl0, ok_cnt;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_bit == 1'b1, "R2", "tx_bit after reset", int'(tx_bit), 1);
    chk(done == 1'b0, "R7", "done after reset", int'(done), 0);

    // R2: disabled line stays marking
    ok_cnt = 0; ones_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (ce_q) begin ones_seen++; if (tx_bit) ok_cnt++; end
    end
    chk(ok_cnt == ones_seen && ones_seen > 0, "R2", "disabled line bits at 1", ok_cnt, ones_seen);

    for (int a = 0; a < 128; a++) wr(a, 8'($urandom));

    // R1: idle flags
    link_en = 1'b1;
    repeat (100) @(negedge clk);
    armed = 1'b1;
    fl0 = idle_flags;
    repeat (400) @(negedge clk);
    chk(idle_flags - fl0 >= 40, "R1", "idle flags seen", idle_flags - fl0, 40);
    chk(frames == 0 && misaligned == 0, "R1", "no frame or broken flag when idle",
        frames + misaligned, 0);

    // R3 R5: 79-byte frame with check sequence
    send_frame(1'b0, 1'b1, 14, 1'b1, "R5");

    // R8: held request gives no second frame
    f0 = frames;
    repeat (2000) @(negedge clk);
    chk(frames == f0, "R8", "no resend while request held", frames, f0);
    chk(done == 1'b1, "R8", "done stays set while request held", int'(done), 1);
    // R8: toggled request resends identical frame
    send_frame(1'b0, 1'b1, 14, 1'b1, "R8");

    // R6: no check bytes, deliberately wrong check value in buffer
    wr(4, 8'hDE); wr(5, 8'hAD);
    send_frame(1'b1, 1'b0, 5, 1'b0, "R6");

    // R4: all-ones payload, stuffing at every border and before closing flag
    for (int a = 0; a < 20; a++) wr(a, 8'hFF);
    send_frame(1'b1, 1'b0, 19, 1'b0, "R4");
    send_frame(1'b1, 1'b0, 19, 1'b1, "R4");
    // R4: flag patterns and border-crossing runs inside the payload
    for (int a = 0; a < 12; a++) wr(a, (a % 3 == 0) ? 8'h7E : ((a % 3 == 1) ? 8'hF8 : 8'h1F));
    send_frame(1'b1, 1'b0, 11, 1'b1, "R4");

    // R3: both end flags set -> buffer 0 wins
    send_frame(1'b1, 1'b1, 30, 1'b1, "R3");
    // R3: no end flag -> all 128 bytes
    send_frame(1'b0, 1'b0, 0, 1'b1, "R3");
    // R3: end at buffer 1 last byte
    send_frame(1'b0, 1'b1, 63, 1'b0, "R3");

    // R9: sparse strobes
    ce_pct = 35;
    send_frame(1'b0, 1'b1, 3, 1'b1, "R9");
    ce_pct = 100;

    // random frames
    for (int i = 0; i < 4; i++) begin
      for (int a = 0; a < 128; a++) if (($urandom % 4) == 0) wr(a, 8'($urandom));
      send_frame(1'($urandom), 1'($urandom), int'($urandom % 64), 1'($urandom), "R3");
    end

    chk(misaligned == 0, "R4", "byte-aligned frames on line", misaligned, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule